// File: doc/BRIEF.md
# Indirect Bus Command Bridge

This block gives a host with a 64-bit register port a way to reach a 32-bit internal peripheral bus one transaction at a time. The host sees four 8-byte, big-endian registers: control, reset, status and data. Storing a word into the control register is itself the command. The direction, byte count and internal-bus address are taken from fields of that word, and the bridge then makes one request on the internal bus.

When the internal bus answers, the bridge builds a status word. The status word holds a done flag and, for a read, the four returned bytes. If a read fails, the data field is filled with ones. Reading status returns that word and clears it in the same access, so software polls status until the done flag appears.

While a transaction is outstanding, the bridge holds a busy flag and ignores further commands.

Top module: `ibus_cmd_bridge`

## Requirements
- R1: After reset, busy and bus_req_valid are 0, and reads of the status and data registers return 0.
- R2: The register is chosen by host_word_addr (host address bits [4:3]): 0 control, 1 reset, 2 status, 3 data. Reads of control and reset return 0. A write to status or to reset changes no register and starts no transaction.
- R3: A write to the data register stores host_wdata[63:32]. A read of the data register returns that value in bits [63:32] and zeros in bits [31:0].
- R4: A control write accepted while idle drives bus_req_valid high on the next cycle. The request carries these fields of the control word: bus_req_write = NOT bit 48 (bit 48 = 1 means read), bus_req_size = bits [59:56], bus_req_addr = bits [31:0]. The request and its fields hold steady until bus_req_ready is seen.
- R5: A control write whose byte count (bits [59:56]) is greater than 8 is dropped. No request is made, busy stays 0, and status keeps its previous value.
- R6: After a read that completes with no error, status equals bit 11 (done) ORed with the returned 32-bit data placed at bits [57:26]. The first byte, bus_rsp_rdata[31:24], lands at the top of that field.
- R7: After a read that completes with bus_rsp_err set, status equals bit 11 with bits [57:26] all ones.
- R8: For a write command, bus_req_wdata is the data register value at the time of the command, most significant byte first. After the response, status equals bit 11 alone, whatever bus_rsp_err is.
- R9: A status read returns the current value, and status is 0 afterwards. A status load in the same cycle takes precedence over the clear.
- R10: busy is 1 from the cycle after an accepted command until the response. Control writes made while busy start nothing and do not change the request in flight.
- R11: A response is taken only after the request handshake. The response clears busy and loads status at the same clock edge, so both are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe; read data is valid in the same cycle |
| host_word_addr | input | 2 | Register select, host address bits [4:3] |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for the selected register |
| busy | output | 1 | A transaction is outstanding |
| bus_req_valid | output | 1 | Internal-bus request valid |
| bus_req_ready | input | 1 | Internal-bus request accepted |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_size | output | 4 | Byte count of the request |
| bus_req_addr | output | 32 | Internal-bus address |
| bus_req_wdata | output | 32 | Write data, first byte in bits [31:24] |
| bus_rsp_valid | input | 1 | Single-cycle response strobe |
| bus_rsp_err | input | 1 | Response reports failure |
| bus_rsp_rdata | input | 32 | Response read data |

## Verification
Each result has a fixed due cycle, counted from the clock edge that takes the stimulus:

| Result | When it is due |
|---|---|
| Request and busy | The cycle after the edge that takes the control write |
| Request dropped | The cycle after the edge at which bus_req_ready is high |
| Busy cleared and status loaded | The cycle after the edge that takes the response strobe |
| Read data | In the same cycle as the read strobe |
| Clear-on-read | Shows on the next status read |

The bench drives inputs on falling edges and samples one falling edge after the edge under test. Read data is sampled a step after the strobe is raised. The ready and response delays are randomised, and every check is placed relative to the edge that should produce the change.

// File: rtl/ibcb_pkg.sv
package ibcb_pkg;

  localparam int HOST_W    = 64;
  localparam int BUS_DW    = 32;
  localparam int BUS_AW    = 32;
  localparam int SIZE_W    = 4;
  localparam int IDX_W     = 2;
  localparam int MAX_BYTES = 8;
  localparam int RW_BIT    = 48;
  localparam int SIZE_LSB  = 56;
  localparam int DONE_BIT  = 11;
  localparam int RDATA_LSB = 26;
  localparam int DATA_LSB  = HOST_W - BUS_DW;

  typedef enum logic [IDX_W-1:0] {
    REG_CTRL = 2'd0,
    REG_RST  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic              is_read;
    logic [SIZE_W-1:0] size;
    logic [BUS_AW-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [HOST_W-1:0] w);
    cmd_t c;
    c.is_read = w[RW_BIT];
    c.size    = w[SIZE_LSB +: SIZE_W];
    c.addr    = w[BUS_AW-1:0];
    return c;
  endfunction

  function automatic logic size_ok(input logic [SIZE_W-1:0] s);
    return int'(s) <= MAX_BYTES;
  endfunction

  function automatic logic [HOST_W-1:0] pack_status(input logic [BUS_DW-1:0] d,
                                                    input logic err,
                                                    input logic is_read);
    logic [HOST_W-1:0] v;
    logic [BUS_DW-1:0] field;
    v = '0;
    v[DONE_BIT] = 1'b1;
    if (is_read) begin
      field = err ? {BUS_DW{1'b1}} : d;
      v[RDATA_LSB +: BUS_DW] = field;
    end
    return v;
  endfunction

endpackage

// File: rtl/ibcb_regfile.sv
module ibcb_regfile
  import ibcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_idx_e          idx,
  input  logic [BUS_DW-1:0] data_in,
  input  logic              stat_load,
  input  logic [HOST_W-1:0] stat_value,
  output logic [HOST_W-1:0] rdata,
  output logic [BUS_DW-1:0] data_q,
  output logic [HOST_W-1:0] stat_q
);

  logic data_wr;
  logic stat_rd;

  assign data_wr = wr_en && (idx == REG_DATA);
  assign stat_rd = rd_en && (idx == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= data_in;
    end
  end

  // A load from the sequencer wins over the clear-on-read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_load) begin
      stat_q <= stat_value;
    end else if (stat_rd) begin
      stat_q <= '0;
    end
  end

  always_comb begin
    unique case (idx)
      REG_STAT: rdata = stat_q;
      REG_DATA: rdata = {data_q, {DATA_LSB{1'b0}}};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/ibcb_sequencer.sv
module ibcb_sequencer
  import ibcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [HOST_W-1:0] cmd_word,
  input  logic [BUS_DW-1:0] data_q,
  input  logic              bus_req_ready,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [BUS_DW-1:0] bus_rsp_rdata,
  output logic              bus_req_valid,
  output logic              bus_req_write,
  output logic [SIZE_W-1:0] bus_req_size,
  output logic [BUS_AW-1:0] bus_req_addr,
  output logic [BUS_DW-1:0] bus_req_wdata,
  output logic              busy,
  output logic              cmd_accept,
  output logic              stat_load,
  output logic [HOST_W-1:0] stat_value
);

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  sq_state_e         state;
  cmd_t              cmd_in;
  cmd_t              cmd_q;
  logic [BUS_DW-1:0] wdata_q;

  assign cmd_in     = decode_cmd(cmd_word);
  assign cmd_accept = cmd_wr && (state == SQ_IDLE) && size_ok(cmd_in.size);
  assign stat_load  = (state == SQ_WAIT) && bus_rsp_valid;
  assign stat_value = pack_status(bus_rsp_rdata, bus_rsp_err, cmd_q.is_read);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cmd_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (cmd_accept) begin
          cmd_q   <= cmd_in;
          wdata_q <= data_q;
          state   <= SQ_REQ;
        end
        SQ_REQ:  if (bus_req_ready) state <= SQ_WAIT;
        SQ_WAIT: if (bus_rsp_valid) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy          = (state != SQ_IDLE);
  assign bus_req_valid = (state == SQ_REQ);
  assign bus_req_write = !cmd_q.is_read;
  assign bus_req_size  = cmd_q.size;
  assign bus_req_addr  = cmd_q.addr;
  assign bus_req_wdata = wdata_q;

endmodule

// File: rtl/ibus_cmd_bridge.sv
module ibus_cmd_bridge
  import ibcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [IDX_W-1:0]  host_word_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              busy,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [SIZE_W-1:0] bus_req_size,
  output logic [BUS_AW-1:0] bus_req_addr,
  output logic [BUS_DW-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [BUS_DW-1:0] bus_rsp_rdata
);

  reg_idx_e          idx;
  logic              cmd_wr;
  logic              cmd_accept;
  logic              stat_load;
  logic [HOST_W-1:0] stat_value;
  logic [HOST_W-1:0] stat_q;
  logic [BUS_DW-1:0] data_q;

  assign idx    = reg_idx_e'(host_word_addr);
  assign cmd_wr = host_wr_en && (idx == REG_CTRL);

  ibcb_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr_en),
    .rd_en      (host_rd_en),
    .idx        (idx),
    .data_in    (host_wdata[HOST_W-1:DATA_LSB]),
    .stat_load  (stat_load),
    .stat_value (stat_value),
    .rdata      (host_rdata),
    .data_q     (data_q),
    .stat_q     (stat_q)
  );

  ibcb_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .cmd_word      (host_wdata),
    .data_q        (data_q),
    .bus_req_ready (bus_req_ready),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_err   (bus_rsp_err),
    .bus_rsp_rdata (bus_rsp_rdata),
    .bus_req_valid (bus_req_valid),
    .bus_req_write (bus_req_write),
    .bus_req_size  (bus_req_size),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .busy          (busy),
    .cmd_accept    (cmd_accept),
    .stat_load     (stat_load),
    .stat_value    (stat_value)
  );

endmodule

// File: rtl/ibcb_checker.sv
module ibcb_checker
  import ibcb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic [IDX_W-1:0]  host_word_addr,
  input logic [SIZE_W-1:0] ctrl_size,
  input logic [HOST_W-1:0] host_rdata,
  input logic              busy,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [BUS_AW-1:0] bus_req_addr,
  input logic              bus_rsp_valid,
  input logic              cmd_accept,
  input logic              stat_load,
  input logic [HOST_W-1:0] stat_q
);

  // R4
  accept_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (bus_req_valid && busy));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_addr)));

  // R5
  oversize_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_word_addr == 2'd0 && int'(ctrl_size) > MAX_BYTES && !busy)
      |=> (!busy && !bus_req_valid));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && host_word_addr == 2'd2 && !stat_load) |=> (stat_q == '0));

  // R11
  rsp_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req_valid && bus_rsp_valid) |=> !busy);

  // R2
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && host_word_addr[1] == 1'b0) |-> (host_rdata == '0));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_accept);

endmodule

bind ibus_cmd_bridge ibcb_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr_en     (host_wr_en),
  .host_rd_en     (host_rd_en),
  .host_word_addr (host_word_addr),
  .ctrl_size      (host_wdata[ibcb_pkg::SIZE_LSB +: ibcb_pkg::SIZE_W]),
  .host_rdata     (host_rdata),
  .busy           (busy),
  .bus_req_valid  (bus_req_valid),
  .bus_req_ready  (bus_req_ready),
  .bus_req_addr   (bus_req_addr),
  .bus_rsp_valid  (bus_rsp_valid),
  .cmd_accept     (cmd_accept),
  .stat_load      (stat_load),
  .stat_q         (stat_q)
);

// File: tb/tb_ibus_cmd_bridge.sv
module tb_ibus_cmd_bridge;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [1:0]  host_word_addr = 2'd0;
  logic [63:0] host_wdata = 64'd0;
  logic [63:0] host_rdata;
  logic        busy;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic        bus_req_write;
  logic [3:0]  bus_req_size;
  logic [31:0] bus_req_addr;
  logic [31:0] bus_req_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0;
  logic [31:0] bus_rsp_rdata = 32'd0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibus_cmd_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_word_addr(host_word_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_size(bus_req_size),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .bus_rsp_rdata(bus_rsp_rdata)
  );

  localparam logic [1:0] I_CTRL = 2'd0;
  localparam logic [1:0] I_RST  = 2'd1;
  localparam logic [1:0] I_STAT = 2'd2;
  localparam logic [1:0] I_DATA = 2'd3;

  function automatic logic [63:0] mk_ctrl(input bit rd, input logic [3:0] sz,
                                          input logic [31:0] a, input logic [63:0] junk);
    logic [63:0] w;
    w = junk;
    w[48] = rd;
    w[59:56] = sz;
    w[31:0] = a;
    return w;
  endfunction

  function automatic logic [63:0] exp_stat(input bit rd, input bit err, input logic [31:0] d);
    if (!rd) return 64'h0000_0000_0000_0800;
    if (err) return 64'h0000_0000_0000_0800 | (64'h0000_0000_FFFF_FFFF << 26);
    return {6'b0, d, 26'b0} | 64'h0000_0000_0000_0800;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_word_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [63:0] v);
    @(negedge clk);
    host_rd_en = 1'b1; host_word_addr = a;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic run_cmd(input bit rd, input logic [3:0] sz, input logic [31:0] a,
                         input logic [31:0] wd, input logic [31:0] rsp_d, input bit err,
                         input int rdy_dly, input int rsp_dly, input bit rd_stat);
    logic [63:0] v;
    if (!rd) host_write(I_DATA, {wd, $urandom()});
    host_write(I_CTRL, mk_ctrl(rd, sz, a, {$urandom(), $urandom()}));
    chk("R10 busy after command", 64'(busy), 64'd1);
    chk("R4 req valid", 64'(bus_req_valid), 64'd1);
    chk("R4 req addr", 64'(bus_req_addr), 64'(a));
    chk("R4 req size", 64'(bus_req_size), 64'(sz));
    chk("R4 req write", 64'(bus_req_write), 64'(!rd));
    if (!rd) chk("R8 req wdata", 64'(bus_req_wdata), 64'(wd));
    repeat (rdy_dly) @(negedge clk);
    chk("R4 req held", 64'(bus_req_valid), 64'd1);
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
    chk("R4 req dropped after handshake", 64'(bus_req_valid), 64'd0);
    chk("R10 busy while waiting", 64'(busy), 64'd1);
    repeat (rsp_dly) @(negedge clk);
    bus_rsp_valid = 1'b1; bus_rsp_err = err; bus_rsp_rdata = rsp_d;
    @(negedge clk);
    bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0; bus_rsp_rdata = $urandom();
    chk("R11 busy cleared", 64'(busy), 64'd0);
    if (rd_stat) begin
      host_read(I_STAT, v);
      chk(rd ? (err ? "R7 failed read status" : "R6 read status") : "R8 write status",
          v, exp_stat(rd, err, rsp_d));
      host_read(I_STAT, v);
      chk("R9 status cleared", v, 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 req valid", 64'(bus_req_valid), 64'd0);
    host_read(I_STAT, v); chk("R1 status", v, 64'd0);
    host_read(I_DATA, v); chk("R1 data", v, 64'd0);

    // R3 data register capture and readback
    host_write(I_DATA, 64'hA1B2_C3D4_5566_7788);
    host_read(I_DATA, v); chk("R3 data readback", v, 64'hA1B2_C3D4_0000_0000);

    // R2 control and reset read zero, reset write ignored
    host_read(I_CTRL, v); chk("R2 control reads zero", v, 64'd0);
    host_write(I_RST, mk_ctrl(1'b1, 4'd4, 32'h1234_5678, 64'hFFFF_FFFF_FFFF_FFFF));
    chk("R2 reset write starts nothing", 64'(busy), 64'd0);
    host_read(I_RST, v); chk("R2 reset reads zero", v, 64'd0);
    host_read(I_DATA, v); chk("R2 reset write keeps data", v, 64'hA1B2_C3D4_0000_0000);

    // R6 directed read, first byte most significant
    run_cmd(1'b1, 4'd4, 32'hC001_2024, 32'h0, 32'h1122_3344, 1'b0, 0, 0, 1'b1);
    // R7 failed read fills ones
    run_cmd(1'b1, 4'd1, 32'hD001_0060, 32'h0, 32'h0000_0000, 1'b1, 2, 1, 1'b1);
    // R8 write with error still just done
    run_cmd(1'b0, 4'd4, 32'hE000_0010, 32'hDEAD_BEEF, 32'h0, 1'b1, 1, 3, 1'b1);
    // R4 boundary size 8 and size 0
    run_cmd(1'b1, 4'd8, 32'h0000_0000, 32'h0, 32'hFFFF_0000, 1'b0, 0, 0, 1'b1);
    run_cmd(1'b0, 4'd0, 32'hFFFF_FFFC, 32'h0102_0304, 32'h0, 1'b0, 0, 0, 1'b1);

    // R5 oversize dropped, status kept; R2 status write ignored
    run_cmd(1'b1, 4'd2, 32'hC001_2038, 32'h0, 32'h8000_0001, 1'b0, 1, 0, 1'b0);
    host_write(I_CTRL, mk_ctrl(1'b1, 4'd9, 32'h1111_2222, 64'd0));
    chk("R5 oversize no busy", 64'(busy), 64'd0);
    chk("R5 oversize no request", 64'(bus_req_valid), 64'd0);
    host_write(I_CTRL, mk_ctrl(1'b0, 4'd15, 32'h3333_4444, 64'd0));
    chk("R5 size 15 no busy", 64'(busy), 64'd0);
    host_write(I_STAT, 64'd0);
    host_read(I_STAT, v);
    chk("R5 status kept after dropped command", v, exp_stat(1'b1, 1'b0, 32'h8000_0001));
    host_read(I_STAT, v); chk("R9 status cleared", v, 64'd0);

    // R10 control write while busy is ignored
    host_write(I_CTRL, mk_ctrl(1'b1, 4'd4, 32'hAAAA_0000, 64'd0));
    host_write(I_CTRL, mk_ctrl(1'b0, 4'd2, 32'hBBBB_0000, 64'd0));
    chk("R10 request unchanged addr", 64'(bus_req_addr), 64'hAAAA_0000);
    chk("R10 request unchanged dir", 64'(bus_req_write), 64'd0);
    bus_req_ready = 1'b1; @(negedge clk); bus_req_ready = 1'b0;
    host_write(I_CTRL, mk_ctrl(1'b0, 4'd2, 32'hCCCC_0000, 64'd0));
    chk("R10 no request from write in wait", 64'(bus_req_valid), 64'd0);
    bus_rsp_valid = 1'b1; bus_rsp_rdata = 32'h5A5A_A5A5; @(negedge clk); bus_rsp_valid = 1'b0;
    chk("R11 busy cleared", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R10 nothing queued", 64'(bus_req_valid), 64'd0);
    host_read(I_STAT, v); chk("R6 status after ignored writes", v, exp_stat(1'b1, 1'b0, 32'h5A5A_A5A5));

    // R11 response before handshake is not taken
    host_write(I_CTRL, mk_ctrl(1'b1, 4'd4, 32'h7777_0000, 64'd0));
    bus_rsp_valid = 1'b1; bus_rsp_rdata = 32'h1; @(negedge clk); bus_rsp_valid = 1'b0;
    chk("R11 early response ignored", 64'(busy), 64'd1);
    run_cmd(1'b1, 4'd4, 32'h7777_0000, 32'h0, 32'h0, 1'b0, 0, 0, 1'b0);
    host_read(I_STAT, v);

    // Random traffic
    for (int i = 0; i < 60; i++) begin
      bit rd;
      logic [3:0] sz;
      rd = 1'($urandom() % 2);
      sz = 4'($urandom() % 9);
      run_cmd(rd, sz, $urandom(), $urandom(), $urandom(), ($urandom() % 4) == 0,
              int'($urandom() % 4), int'($urandom() % 4), 1'b1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule